// File: doc/BRIEF.md
# Auto-Advancing 64-bit Compare Timer

This block watches a free-running 64-bit count that arrives on an input port and raises an interrupt when the count reaches a programmed 64-bit target. It has two modes. In one-shot mode the target stays where software put it. In periodic mode the hardware adds a programmed step to the target on every hit, so events keep recurring and software does not have to reprogram the target each time.

Software reaches the block through a simple 32-bit register port. Writes take effect on the clock edge. Reads are combinational on the address. The target is split into a low word and a high word. Next to it sit a step register, a two-bit control register (compare enable and auto-advance), an interrupt enable, a sticky pending flag and a write-acknowledge register. The write-acknowledge register has one flag for each timing-critical register, and that flag records that a write to the register has been applied.

Top module: `acmp_timer`

## Requirements
- R1: After reset every register reads 0 and irq_o is 0.
- R2: The register map is: target low word at 0x200, target high word at 0x204, 32-bit step at 0x208 (zero-extended to 64 bits), control at 0x240, pending at 0x244, interrupt enable at 0x248, write-acknowledge at 0x24C. Control bit 0 is the compare enable and bit 1 is auto-advance. Unimplemented control bits and interrupt-enable bits 31:1 read 0. Unmapped addresses read 0 and ignore writes.
- R3: A write to 0x200, 0x204, 0x208 or 0x240 sets bit 0, 1, 2 or 16 of 0x24C, respectively, from the next cycle. Writing 1 to one of those bits clears it, and writing 0 leaves it unchanged.
- R4: A hit occurs in any cycle where control bit 0 is 1 and count_i equals the 64-bit target. From the next cycle the hit sets pending bit 0 at 0x244. When control bit 0 is 0 there is never a hit.
- R5: irq_o is 1 exactly when the pending bit and interrupt-enable bit 0 are both 1.
- R6: Writing 1 to bit 0 of 0x244 clears the pending bit. A hit in the same cycle as the clear wins, so the pending bit stays 1. Further hits leave it set.
- R7: With auto-advance set, every hit replaces the target with target plus step, modulo 2^64, with the carry passing from the low word into the high word.
- R8: With auto-advance clear, a hit leaves the target unchanged.
- R9: If a bus write to either target word coincides with a hit, the written word takes the bus data, the other word keeps its value, and no advance happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| count_i | input | 64 | Global 64-bit count |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 12 | Register byte offset |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Combinational read data for bus_addr_i |
| irq_o | output | 1 | Interrupt, pending AND enable |

## Verification
The assertions check several properties on every cycle. A hit always sets the pending flag. A disabled compare never hits. The pending flag survives any cycle without a clear. The target either advances by exactly the step or holds, depending on the mode. A write to each target word is always acknowledged. The bench scenarios cover what those per-cycle rules cannot reach: the exact register map and readback masking, the 32-bit carry and the 64-bit wrap in periodic mode, a set-versus-clear collision on the pending flag, and a bus write that collides with an advance.

// File: rtl/acmp_pkg.sv
package acmp_pkg;
  localparam int ADDR_W = 12;

  localparam logic [ADDR_W-1:0] A_CMP_LO = 12'h200;
  localparam logic [ADDR_W-1:0] A_CMP_HI = 12'h204;
  localparam logic [ADDR_W-1:0] A_STEP   = 12'h208;
  localparam logic [ADDR_W-1:0] A_CTRL   = 12'h240;
  localparam logic [ADDR_W-1:0] A_PEND   = 12'h244;
  localparam logic [ADDR_W-1:0] A_IEN    = 12'h248;
  localparam logic [ADDR_W-1:0] A_WACK   = 12'h24C;

  localparam int NACK = 4;

  typedef struct packed {
    logic auto_adv;
    logic enable;
  } ctrl_t;

  // bit position of each write-acknowledge flag
  function automatic int ack_pos(int i);
    case (i)
      0: return 0;
      1: return 1;
      2: return 2;
      default: return 16;
    endcase
  endfunction

  // register tracked by each write-acknowledge flag
  function automatic logic [ADDR_W-1:0] ack_addr(int i);
    case (i)
      0: return A_CMP_LO;
      1: return A_CMP_HI;
      2: return A_STEP;
      default: return A_CTRL;
    endcase
  endfunction
endpackage

// File: rtl/acmp_core.sv
module acmp_core #(
  parameter int CNT_W  = 64,
  parameter int STEP_W = 32
) (
  input  logic [CNT_W-1:0]  count_i,
  input  logic [CNT_W-1:0]  target_i,
  input  logic [STEP_W-1:0] step_i,
  input  logic              enable_i,
  output logic              hit_o,
  output logic [CNT_W-1:0]  target_nxt_o
);
  assign hit_o        = enable_i && (count_i == target_i);
  assign target_nxt_o = target_i + CNT_W'(step_i);  // wraps modulo 2^CNT_W
endmodule

// File: rtl/acmp_pend.sv
module acmp_pend (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hit_i,
  input  logic clr_i,
  input  logic ien_i,
  output logic pend_o,
  output logic irq_o
);
  logic pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pend_q <= 1'b0;
    else if (hit_i)  pend_q <= 1'b1;  // new event beats a clear
    else if (clr_i)  pend_q <= 1'b0;
  end

  assign pend_o = pend_q;
  assign irq_o  = pend_q & ien_i;
endmodule

// File: rtl/acmp_regfile.sv
module acmp_regfile
  import acmp_pkg::*;
#(
  parameter int BUS_W = 32,
  localparam int CNT_W = 2 * BUS_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BUS_W-1:0]  wdata_i,
  input  logic              adv_i,
  input  logic [CNT_W-1:0]  target_nxt_i,
  input  logic              pend_i,
  output logic [CNT_W-1:0]  target_o,
  output logic [BUS_W-1:0]  step_o,
  output ctrl_t             ctrl_o,
  output logic              ien_o,
  output logic [NACK-1:0]   ack_o,
  output logic              pend_clr_o,
  output logic [BUS_W-1:0]  rdata_o
);
  logic [1:0][BUS_W-1:0] target_q;
  logic [BUS_W-1:0]      step_q;
  ctrl_t                 ctrl_q;
  logic                  ien_q;
  logic [NACK-1:0]       ack_q;
  logic                  target_wr;

  assign target_wr = we_i && (addr_i == A_CMP_LO || addr_i == A_CMP_HI);

  for (genvar w = 0; w < 2; w++) begin : g_word
    localparam logic [ADDR_W-1:0] WADDR = A_CMP_LO + ADDR_W'(4 * w);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                        target_q[w] <= '0;
      else if (we_i && addr_i == WADDR)   target_q[w] <= wdata_i;
      else if (adv_i && !target_wr)       target_q[w] <= target_nxt_i[w*BUS_W +: BUS_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q <= '0;
      ctrl_q <= '0;
      ien_q  <= 1'b0;
    end else if (we_i) begin
      if (addr_i == A_STEP) step_q <= wdata_i;
      if (addr_i == A_CTRL) ctrl_q <= ctrl_t'(wdata_i[1:0]);
      if (addr_i == A_IEN)  ien_q  <= wdata_i[0];
    end
  end

  for (genvar i = 0; i < NACK; i++) begin : g_ack
    localparam int P = ack_pos(i);
    localparam logic [ADDR_W-1:0] TA = ack_addr(i);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                        ack_q[i] <= 1'b0;
      else if (we_i && addr_i == TA)                      ack_q[i] <= 1'b1;
      else if (we_i && addr_i == A_WACK && wdata_i[P])    ack_q[i] <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_CMP_LO: rdata_o = target_q[0];
      A_CMP_HI: rdata_o = target_q[1];
      A_STEP:   rdata_o = step_q;
      A_CTRL:   rdata_o[1:0] = ctrl_q;
      A_PEND:   rdata_o[0] = pend_i;
      A_IEN:    rdata_o[0] = ien_q;
      A_WACK:   for (int i = 0; i < NACK; i++) rdata_o[ack_pos(i)] = ack_q[i];
      default:  rdata_o = '0;
    endcase
  end

  assign target_o   = target_q;
  assign step_o     = step_q;
  assign ctrl_o     = ctrl_q;
  assign ien_o      = ien_q;
  assign ack_o      = ack_q;
  assign pend_clr_o = we_i && addr_i == A_PEND && wdata_i[0];
endmodule

// File: rtl/acmp_timer.sv
module acmp_timer
  import acmp_pkg::*;
#(
  parameter int BUS_W = 32,
  localparam int CNT_W = 2 * BUS_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [BUS_W-1:0]  bus_wdata_i,
  output logic [BUS_W-1:0]  bus_rdata_o,
  output logic              irq_o
);
  logic [CNT_W-1:0] target_q, target_nxt;
  logic [BUS_W-1:0] step_q;
  ctrl_t            ctrl_q;
  logic             ien_q, pend_q, pend_clr, hit, adv;
  logic [NACK-1:0]  ack_q;

  assign adv = hit && ctrl_q.auto_adv;

  acmp_regfile #(.BUS_W(BUS_W)) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .we_i         (bus_we_i),
    .addr_i       (bus_addr_i),
    .wdata_i      (bus_wdata_i),
    .adv_i        (adv),
    .target_nxt_i (target_nxt),
    .pend_i       (pend_q),
    .target_o     (target_q),
    .step_o       (step_q),
    .ctrl_o       (ctrl_q),
    .ien_o        (ien_q),
    .ack_o        (ack_q),
    .pend_clr_o   (pend_clr),
    .rdata_o      (bus_rdata_o)
  );

  acmp_core #(.CNT_W(CNT_W), .STEP_W(BUS_W)) u_core (
    .count_i      (count_i),
    .target_i     (target_q),
    .step_i       (step_q),
    .enable_i     (ctrl_q.enable),
    .hit_o        (hit),
    .target_nxt_o (target_nxt)
  );

  acmp_pend u_pend (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hit_i  (hit),
    .clr_i  (pend_clr),
    .ien_i  (ien_q),
    .pend_o (pend_q),
    .irq_o  (irq_o)
  );
endmodule

// File: rtl/acmp_timer_chk.sv
module acmp_timer_chk
  import acmp_pkg::*;
#(
  parameter int BUS_W = 32,
  localparam int CNT_W = 2 * BUS_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_we_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic              wd0_i,
  input logic              irq_o,
  input logic              hit,
  input logic              enable,
  input logic              auto_adv,
  input logic              pend_q,
  input logic              ien_q,
  input logic [NACK-1:0]   ack_q,
  input logic [CNT_W-1:0]  target_q,
  input logic [BUS_W-1:0]  step_q
);
  logic tgt_wr, pend_w1c;
  assign tgt_wr   = bus_we_i && (bus_addr_i == A_CMP_LO || bus_addr_i == A_CMP_HI);
  assign pend_w1c = bus_we_i && bus_addr_i == A_PEND && wd0_i;

  always @(posedge clk_i)
    if (!rst_ni) assert_reset_quiet_R1: assert (!irq_o && !pend_q);

  assert_hit_sets_pend_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit |=> pend_q);
  assert_no_hit_disabled_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable |-> !hit);
  assert_irq_masked_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ien_q |-> !irq_o);
  assert_pend_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !pend_w1c) |=> pend_q);
  assert_advance_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && auto_adv && !tgt_wr) |=> target_q == $past(target_q) + CNT_W'($past(step_q)));
  assert_oneshot_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && !auto_adv && !tgt_wr) |=> $stable(target_q));
  assert_ack_lo_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && bus_addr_i == A_CMP_LO) |=> ack_q[0]);
  assert_ack_hi_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && bus_addr_i == A_CMP_HI) |=> ack_q[1]);
endmodule

bind acmp_timer acmp_timer_chk #(.BUS_W(BUS_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bus_we_i   (bus_we_i),
  .bus_addr_i (bus_addr_i),
  .wd0_i      (bus_wdata_i[0]),
  .irq_o      (irq_o),
  .hit        (hit),
  .enable     (ctrl_q.enable),
  .auto_adv   (ctrl_q.auto_adv),
  .pend_q     (pend_q),
  .ien_q      (ien_q),
  .ack_q      (ack_q),
  .target_q   (target_q),
  .step_q     (step_q)
);

// File: tb/acmp_timer_bench.sv
module acmp_timer_bench;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] count = '0;
  logic        we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  acmp_timer u_acmp_timer (
    .clk_i(clk), .rst_ni(rst_n), .count_i(count), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
  );

  // {addr, write data, expected readback}
  localparam logic [75:0] VEC [7] = '{
    {12'h200, 32'hDEADBEEF, 32'hDEADBEEF},
    {12'h204, 32'h12345678, 32'h12345678},
    {12'h208, 32'h00000010, 32'h00000010},
    {12'h240, 32'hFFFFFFFC, 32'h00000000},
    {12'h248, 32'hFFFFFFFF, 32'h00000001},
    {12'h300, 32'hFFFFFFFF, 32'h00000000},
    {12'h204, 32'h0000_0000, 32'h00000000}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic pulse_count(input logic [63:0] c, input logic [63:0] after);
    @(negedge clk);
    count = c;
    @(negedge clk);
    count = after;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    foreach (VEC[i]) begin
      rd(VEC[i][75:64], v);
      chk("R1 reset read", v, 0);
    end
    rd(12'h24C, v); chk("R1 ack reset", v, 0);
    chk("R1 irq reset", irq, 0);

    // R2: table-driven write/readback
    for (int i = 0; i < 7; i++) begin
      wr(VEC[i][75:64], VEC[i][63:32]);
      rd(VEC[i][75:64], v);
      chk("R2 readback", v, VEC[i][31:0]);
    end

    // R3: write acknowledge set and clear
    rd(12'h24C, v); chk("R3 ack all set", v, 32'h0001_0007);
    wr(12'h24C, 32'h0000_0005);
    rd(12'h24C, v); chk("R3 ack partial clear", v, 32'h0001_0002);
    wr(12'h24C, 32'h0);
    rd(12'h24C, v); chk("R3 ack write zero", v, 32'h0001_0002);
    wr(12'h24C, 32'hFFFF_FFFF);
    rd(12'h24C, v); chk("R3 ack clear all", v, 0);

    // R4/R8: one-shot hit at target 100
    wr(12'h200, 32'd100); wr(12'h204, 0); wr(12'h248, 1); wr(12'h240, 32'h1);
    count = 64'd99;
    @(negedge clk);
    rd(12'h244, v); chk("R4 no hit before target", v, 0);
    pulse_count(64'd100, 64'd101);
    rd(12'h244, v); chk("R4 pending after hit", v, 1);
    chk("R5 irq with enable", irq, 1);
    rd(12'h200, v); chk("R8 one-shot lo held", v, 100);
    rd(12'h204, v); chk("R8 one-shot hi held", v, 0);

    // R5: mask
    wr(12'h248, 0);
    chk("R5 irq masked", irq, 0);
    rd(12'h244, v); chk("R5 pending survives mask", v, 1);
    wr(12'h248, 1);
    chk("R5 irq unmasked", irq, 1);

    // R6: clear, then clear colliding with hit
    wr(12'h244, 1);
    rd(12'h244, v); chk("R6 w1c clears", v, 0);
    chk("R6 irq after clear", irq, 0);
    @(negedge clk);
    count = 64'd100; we = 1'b1; addr = 12'h244; wdata = 1;
    @(negedge clk);
    we = 1'b0; count = 64'd101;
    rd(12'h244, v); chk("R6 hit beats clear", v, 1);

    // R4: disabled compare never hits
    wr(12'h240, 0); wr(12'h244, 1);
    pulse_count(64'd100, 64'd101);
    rd(12'h244, v); chk("R4 disabled no hit", v, 0);

    // R7: periodic, carry into high word
    wr(12'h200, 32'hFFFF_FFF0); wr(12'h204, 0); wr(12'h208, 32'h20); wr(12'h240, 32'h3);
    pulse_count(64'h0000_0000_FFFF_FFF0, 64'h0);
    rd(12'h200, v); chk("R7 carry lo", v, 32'h10);
    rd(12'h204, v); chk("R7 carry hi", v, 32'h1);
    pulse_count(64'h0000_0001_0000_0010, 64'h0);
    rd(12'h200, v); chk("R7 second advance lo", v, 32'h30);
    // R7: 64-bit wrap
    wr(12'h240, 0);
    wr(12'h200, 32'hFFFF_FFF0); wr(12'h204, 32'hFFFF_FFFF); wr(12'h240, 32'h3);
    pulse_count(64'hFFFF_FFFF_FFFF_FFF0, 64'h0);
    rd(12'h200, v); chk("R7 wrap lo", v, 32'h10);
    rd(12'h204, v); chk("R7 wrap hi", v, 0);

    // R9: bus write to low word collides with advance
    wr(12'h240, 0);
    wr(12'h200, 32'h1000); wr(12'h204, 0); wr(12'h208, 32'h10); wr(12'h244, 1); wr(12'h240, 32'h3);
    @(negedge clk);
    count = 64'h1000; we = 1'b1; addr = 12'h200; wdata = 32'h5000;
    @(negedge clk);
    we = 1'b0; count = 64'h0;
    rd(12'h200, v); chk("R9 bus word wins", v, 32'h5000);
    rd(12'h204, v); chk("R9 other word held", v, 0);
    rd(12'h244, v); chk("R9 hit still pends", v, 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule